// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel that copies a programmed number of units from a source address to a destination address over a simple memory port. Software loads a source address, a destination address, a unit count and a control word, then sets the enable bit. Each unit is moved as a read at the source address, followed by a write of the same data to the destination address. After the write, each address steps up, steps down or stays put, by the unit size in bytes. The count also drops by one.

The channel can run from its own register setting (auto mode) or be paced by an external request line (request mode). In auto mode a mode bit picks one of two bus policies. In burst mode the channel keeps the bus from the first read to the last write. In cycle-steal mode it drops its bus request after every unit and asks again. When the count reaches zero, the channel clears its enable bit and sets a sticky done flag. It raises an interrupt if that is enabled.

Top module: `dma_channel`

## Requirements
- R1: After reset, all four registers read as zero, and bus_req, mem_valid and irq are low.
- R2: The register map uses cfg_addr 0 for the source address, 1 for the destination address and 2 for the unit count. Address 3 is the control word: bit 0 enable, bit 1 done, bit 2 interrupt enable, bits 4:3 size code, bits 6:5 source step, bits 8:7 destination step, bit 9 auto mode, bit 10 burst. Every field reads back as written.
- R3: While enable is 1, writes to the source, destination, count and control fields are ignored. The one exception is that writing 1 to the done bit still clears it.
- R4: Each unit is a read at the source address followed, in the next accepted bus cycle, by a write of the read data to the destination address. The memory port is only driven while bus_req and bus_gnt are both high. It holds its address until mem_ready.
- R5: After each write, each address changes by its step code: 1 adds the unit size, 2 subtracts it, and 0 or 3 leaves it unchanged. The unit size is 1 << code bytes, where size code 3 is treated as 4 bytes. mem_size shows the effective code.
- R6: The count drops by one per completed write. When it reaches zero, enable reads 0 and done reads 1.
- R7: Setting enable with a count of 0 sets done and clears enable with no bus activity.
- R8: In auto cycle-steal mode (bit 9 = 1, bit 10 = 0), bus_req goes low for at least one cycle after every unit. A run of N units therefore shows N rising edges of bus_req.
- R9: In auto burst mode (bits 9 and 10 both 1), bus_req stays high from the first request until the last write, giving a single rising edge per run.
- R10: In request mode (bit 9 = 0), no unit moves without a request. Each rising edge of dreq moves exactly one unit. Up to 2^PW-1 edges seen during a transfer are kept pending. The burst bit has no effect, and bus_req is released after every unit.
- R11: irq is high exactly while done and the interrupt enable are both 1. Writing 1 to control bit 1 clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| dreq | input | 1 | External transfer request, rising edge active |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Effective unit size code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Auto runs are tried with word, halfword, byte and the out-of-range size code. Each run uses a different pairing of up, down and fixed steps on the two addresses, which separates a wrong stride from a wrong direction or a swapped step field. The same runs alternate burst and cycle-steal, and rising edges of bus_req are counted, which tells a held bus from a released one. A zero count shows the immediate-completion path. A request-mode run sends three request edges in quick succession while its burst bit is set, which shows that pending requests are kept and that the burst bit is ignored. The memory stalls every fourth cycle, so a write that does not carry the read data, or an address that moves during a stall, is caught by the scoreboard.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the DMA channel: register offsets, control-word
// bit positions, engine state encoding and the latched channel settings.
package dma_pkg;
    localparam int REG_W = 32;

    localparam logic [1:0] REG_SRC  = 2'd0;
    localparam logic [1:0] REG_DST  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int B_EN    = 0;
    localparam int B_DONE  = 1;
    localparam int B_IE    = 2;
    localparam int B_SZ    = 3;
    localparam int B_SSTEP = 5;
    localparam int B_DSTEP = 7;
    localparam int B_AUTO  = 9;
    localparam int B_BURST = 10;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} eng_state_t;

    typedef struct packed {
        logic       burst;
        logic       auto_mode;
        logic [1:0] dst_step;
        logic [1:0] src_step;
        logic [1:0] size;
        logic       irq_en;
    } chan_cfg_t;

    // Effective size code: code 3 is treated as a 4-byte unit.
    function automatic logic [1:0] unit_size(input logic [1:0] sz);
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction
endpackage

// File: rtl/dma_regs.sv
`timescale 1ns/1ps
// Channel register file. Holds source and destination addresses, the unit
// count and the control word. Applies address steps and the count decrement
// on each completed unit. Assumes step_i and finish_i only arrive while the
// channel is enabled, so they never collide with a software write.
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             step_i,
    input  logic             finish_i,
    output logic [AW-1:0]    sa_o,
    output logic [AW-1:0]    da_o,
    output logic [CW-1:0]    cnt_o,
    output chan_cfg_t        cfg_o,
    output logic             en_o,
    output logic             done_o
);
    logic [AW-1:0] sa_q, da_q;
    logic [CW-1:0] cnt_q;
    chan_cfg_t     cfg_q;
    logic          en_q, done_q;
    logic          prog_ok;

    // Address after one unit for a given step code and size code.
    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                                 input logic [1:0] mode,
                                                 input logic [1:0] sz);
        logic [AW-1:0] stride;
        stride = AW'(1) << unit_size(sz);
        case (mode)
            2'd1:    return a + stride;
            2'd2:    return a - stride;
            default: return a;
        endcase
    endfunction

    assign prog_ok = cfg_wr && !en_q;

    // Source address: loaded by software while idle, stepped per unit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                sa_q <= '0;
        else if (step_i)                           sa_q <= next_addr(sa_q, cfg_q.src_step, cfg_q.size);
        else if (prog_ok && cfg_addr == REG_SRC)   sa_q <= cfg_wdata[AW-1:0];
    end

    // Destination address: loaded by software while idle, stepped per unit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                da_q <= '0;
        else if (step_i)                           da_q <= next_addr(da_q, cfg_q.dst_step, cfg_q.size);
        else if (prog_ok && cfg_addr == REG_DST)   da_q <= cfg_wdata[AW-1:0];
    end

    // Unit count: loaded while idle, decremented per completed unit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (step_i)                           cnt_q <= cnt_q - CW'(1);
        else if (prog_ok && cfg_addr == REG_CNT)   cnt_q <= cfg_wdata[CW-1:0];
    end

    // Control fields and enable: programmed while idle, enable cleared at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (prog_ok && cfg_addr == REG_CTRL) begin
                cfg_q.irq_en    <= cfg_wdata[B_IE];
                cfg_q.size      <= cfg_wdata[B_SZ +: 2];
                cfg_q.src_step  <= cfg_wdata[B_SSTEP +: 2];
                cfg_q.dst_step  <= cfg_wdata[B_DSTEP +: 2];
                cfg_q.auto_mode <= cfg_wdata[B_AUTO];
                cfg_q.burst     <= cfg_wdata[B_BURST];
                en_q            <= cfg_wdata[B_EN];
            end
            if (finish_i) en_q <= 1'b0;
        end
    end

    // Sticky done flag: set at completion, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                  done_q <= 1'b0;
        else if (finish_i)                                           done_q <= 1'b1;
        else if (cfg_wr && cfg_addr == REG_CTRL && cfg_wdata[B_DONE]) done_q <= 1'b0;
    end

    // Read mux for the selected register.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_SRC: cfg_rdata[AW-1:0] = sa_q;
            REG_DST: cfg_rdata[AW-1:0] = da_q;
            REG_CNT: cfg_rdata[CW-1:0] = cnt_q;
            default: begin
                cfg_rdata[B_EN]         = en_q;
                cfg_rdata[B_DONE]       = done_q;
                cfg_rdata[B_IE]         = cfg_q.irq_en;
                cfg_rdata[B_SZ +: 2]    = cfg_q.size;
                cfg_rdata[B_SSTEP +: 2] = cfg_q.src_step;
                cfg_rdata[B_DSTEP +: 2] = cfg_q.dst_step;
                cfg_rdata[B_AUTO]       = cfg_q.auto_mode;
                cfg_rdata[B_BURST]      = cfg_q.burst;
            end
        endcase
    end

    assign sa_o   = sa_q;
    assign da_o   = da_q;
    assign cnt_o  = cnt_q;
    assign cfg_o  = cfg_q;
    assign en_o   = en_q;
    assign done_o = done_q;
endmodule

// File: rtl/dma_req_ctrl.sv
`timescale 1ns/1ps
// External request tracker. Detects rising edges of a synchronous request
// line and keeps a saturating count of units still owed. Assumes dreq is
// already synchronous to clk. The count is flushed while the channel is not
// armed for request mode.
module dma_req_ctrl #(
    parameter int PW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic arm,
    input  logic take,
    output logic pend_nz
);
    localparam logic [PW-1:0] PEND_MAX = {PW{1'b1}};

    logic          dreq_q;
    logic [PW-1:0] pend_q;
    logic          rise, inc;

    assign rise = dreq && !dreq_q;
    assign inc  = rise && (pend_q != PEND_MAX || take);

    // Previous request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dreq_q <= 1'b0;
        else        dreq_q <= dreq;
    end

    // Pending-unit counter: up on an edge, down when a unit is started.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) pend_q <= '0;
        else begin
            case ({inc, take})
                2'b10:   pend_q <= pend_q + PW'(1);
                2'b01:   pend_q <= pend_q - PW'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend_nz = (pend_q != '0);
endmodule

// File: rtl/dma_engine.sv
`timescale 1ns/1ps
// Transfer sequencer. Requests the bus, then runs one read and one write
// per unit. In auto burst mode it goes straight to the next read; otherwise
// it drops the request after each write. Assumes the arbiter keeps bus_gnt
// high for as long as bus_req stays high once granted.
module dma_engine
    import dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          auto_mode,
    input  logic          burst,
    input  logic          cnt_zero,
    input  logic          cnt_one,
    input  logic          pend_nz,
    output logic          take,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_valid,
    output logic          mem_we,
    output logic          sel_dst,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          step,
    output logic          finish
);
    eng_state_t    state_q, state_d;
    logic [DW-1:0] data_q;
    logic          hold_bus;

    assign hold_bus = auto_mode && burst;

    // Next state and per-state outputs.
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        bus_req   = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        sel_dst   = 1'b0;
        step      = 1'b0;
        finish    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (en) begin
                    if (cnt_zero)                    finish  = 1'b1;
                    else if (auto_mode || pend_nz)   state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    state_d = ST_RD;
                    take    = !auto_mode;
                end
            end
            ST_RD: begin
                bus_req   = 1'b1;
                mem_valid = 1'b1;
                if (mem_ready) state_d = ST_WR;
            end
            default: begin
                bus_req   = 1'b1;
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                sel_dst   = 1'b1;
                if (mem_ready) begin
                    step = 1'b1;
                    if (cnt_one) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = hold_bus ? ST_RD : ST_IDLE;
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Holding register for the unit read from the source.
    always_ff @(posedge clk) begin
        if (!rst_n)                            data_q <= '0;
        else if (state_q == ST_RD && mem_ready) data_q <= mem_rdata;
    end

    assign mem_wdata = data_q;
endmodule

// File: rtl/dma_channel.sv
`timescale 1ns/1ps
// Top of the single-channel DMA. Ties the register file, the request
// tracker and the sequencer together and steers the memory address.
// Assumes AW and CW are at most 32, the register data width.
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          dreq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          irq
);
    logic [AW-1:0] sa, da;
    logic [CW-1:0] cnt;
    chan_cfg_t     cfg;
    logic          chan_en, done_flag;
    logic          run_auto, run_burst;
    logic          step, finish, take, pend_nz, sel_dst;

    assign run_auto  = cfg.auto_mode;
    assign run_burst = cfg.burst;

    dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .step_i   (step),
        .finish_i (finish),
        .sa_o     (sa),
        .da_o     (da),
        .cnt_o    (cnt),
        .cfg_o    (cfg),
        .en_o     (chan_en),
        .done_o   (done_flag)
    );

    dma_req_ctrl #(.PW(PW)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .dreq   (dreq),
        .arm    (chan_en && !run_auto),
        .take   (take),
        .pend_nz(pend_nz)
    );

    dma_engine #(.DW(DW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (chan_en),
        .auto_mode(run_auto),
        .burst    (run_burst),
        .cnt_zero (cnt == '0),
        .cnt_one  (cnt == CW'(1)),
        .pend_nz  (pend_nz),
        .take     (take),
        .bus_req  (bus_req),
        .bus_gnt  (bus_gnt),
        .mem_valid(mem_valid),
        .mem_we   (mem_we),
        .sel_dst  (sel_dst),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata),
        .step     (step),
        .finish   (finish)
    );

    assign mem_addr = sel_dst ? da : sa;
    assign mem_size = unit_size(cfg.size);
    assign irq      = done_flag && cfg.irq_en;
endmodule

// File: rtl/dma_channel_chk.sv
`timescale 1ns/1ps
// Protocol and sequencing checks for the DMA channel, bound to its top.
module dma_channel_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_valid,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          chan_en,
    input logic          done_flag,
    input logic          irq,
    input logic          run_auto,
    input logic          run_burst,
    input logic [CW-1:0] cnt
);
    logic wr_done;
    assign wr_done = mem_valid && mem_we && mem_ready;

    AST_MEM_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_req && bus_gnt)); // R4
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we)); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R4
    AST_NO_BUS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !mem_valid); // R6
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (cnt == CW'($past(cnt) - 1'b1))); // R6
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (cnt == '0 && !chan_en)); // R6
    AST_STEAL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !(run_auto && run_burst)) |=> !bus_req); // R8
    AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && run_auto && run_burst && cnt != CW'(1)) |=> (bus_req && mem_valid && !mem_we)); // R9
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag); // R11
endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_valid(mem_valid),
    .mem_we   (mem_we),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .chan_en  (chan_en),
    .done_flag(done_flag),
    .irq      (irq),
    .run_auto (run_auto),
    .run_burst(run_burst),
    .cnt      (cnt)
);

// File: tb/dma_channel_test.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue the expected bus operations, and a monitor
// pops and compares them as the channel drives the memory port.
module dma_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dreq = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready;
    logic        irq;
    logic [1:0]  stall = 2'd0;

    int total = 0;
    int bad = 0;
    int rises = 0;
    logic prev_req = 1'b0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
    } op_t;
    op_t expq[$];

    always #2 clk = ~clk;

    dma_channel uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h00A5_5A00;
    endfunction

    function automatic logic [31:0] ctrl(input logic en, ie, input logic [1:0] sz, sm, dm,
                                         input logic au, bs);
        return {21'd0, bs, au, dm, sm, sz, ie, 1'b0, en};
    endfunction

    assign mem_rdata = pat(mem_addr);
    assign mem_ready = (stall != 2'd0);

    // Memory stall pattern and a registered arbiter.
    always @(posedge clk) begin
        stall   <= stall + 2'd1;
        bus_gnt <= rst_n && bus_req;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each accepted bus operation with the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !prev_req) rises++;
            prev_req = bus_req;
            if (mem_valid && mem_ready) begin
                if (expq.size() == 0) chk("R4 unexpected bus operation", 32'd1, 32'd0);
                else begin
                    op_t e;
                    e = expq.pop_front();
                    chk("R4 direction", {31'd0, mem_we}, {31'd0, e.we});
                    chk("R5 address", mem_addr, e.addr);
                    chk("R5 size", {30'd0, mem_size}, {30'd0, e.size});
                    if (e.we) chk("R4 write data", mem_wdata, e.data);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic push_exp(input logic [31:0] src, dst, input int n, input logic [1:0] sz, sm, dm,
                            output logic [31:0] fs, fd);
        logic [31:0] s, d, st;
        logic [1:0]  es;
        s = src; d = dst;
        es = (sz == 2'd3) ? 2'd2 : sz;
        st = 32'd1 << es;
        for (int i = 0; i < n; i++) begin
            expq.push_back('{1'b0, s, 32'd0, es});
            expq.push_back('{1'b1, d, pat(s), es});
            s = (sm == 2'd1) ? s + st : (sm == 2'd2) ? s - st : s;
            d = (dm == 2'd1) ? d + st : (dm == 2'd2) ? d - st : d;
        end
        fs = s; fd = d;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cfg_addr = 2'd3;
            #1;
            if (cfg_rdata[1]) return;
        end
        chk("R6 completion timeout", 32'd0, 32'd1);
    endtask

    task automatic run_auto(input logic [31:0] src, dst, input int n, input logic [1:0] sz, sm, dm,
                            input logic bs, ie);
        logic [31:0] fs, fd;
        wr(2'd3, 32'h2);
        push_exp(src, dst, n, sz, sm, dm, fs, fd);
        wr(2'd0, src); wr(2'd1, dst); wr(2'd2, n);
        rises = 0;
        wr(2'd3, ctrl(1'b1, ie, sz, sm, dm, 1'b1, bs));
        wait_done();
        chk("R4 all expected operations seen", expq.size(), 32'd0);
        if (bs) chk("R9 single bus request in burst", rises, 32'd1);
        else    chk("R8 one bus request per unit", rises, n);
        rd_chk(2'd0, fs, "R5 final source address");
        rd_chk(2'd1, fd, "R5 final destination address");
        rd_chk(2'd2, 32'd0, "R6 count reaches zero");
        rd_chk(2'd3, ctrl(1'b0, ie, sz, sm, dm, 1'b1, bs) | 32'h2, "R6 done set and enable clear");
        chk("R11 irq follows done and enable", {31'd0, irq}, {31'd0, ie});
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] fs, fd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(2'd0, 32'd0, "R1 source reset");
        rd_chk(2'd1, 32'd0, "R1 destination reset");
        rd_chk(2'd2, 32'd0, "R1 count reset");
        rd_chk(2'd3, 32'd0, "R1 control reset");
        chk("R1 outputs idle", {29'd0, bus_req, mem_valid, irq}, 32'd0);

        // R2 register read-back
        wr(2'd0, 32'h0000_1234);
        rd_chk(2'd0, 32'h0000_1234, "R2 source read-back");
        wr(2'd2, 32'h0000_00AB);
        rd_chk(2'd2, 32'h0000_00AB, "R2 count read-back");
        wr(2'd3, 32'h0000_07FC);
        rd_chk(2'd3, 32'h0000_07FC, "R2 control read-back");
        wr(2'd3, 32'h0);

        // Auto cycle-steal, words, source up, destination down (R5 R8)
        run_auto(32'h100, 32'h800, 4, 2'd2, 2'd1, 2'd2, 1'b0, 1'b1);
        wr(2'd3, 32'h2);
        rd_chk(2'd3, 32'd0, "R11 done cleared by writing one");
        chk("R11 irq low after clear", {31'd0, irq}, 32'd0);

        // Auto burst, halfwords, source fixed, destination up (R9)
        run_auto(32'h2000, 32'h3000, 5, 2'd1, 2'd0, 2'd1, 1'b1, 1'b1);
        // Cycle-steal, bytes, source down, destination fixed code 3, no irq (R11)
        run_auto(32'h40, 32'h90, 3, 2'd0, 2'd2, 2'd3, 1'b0, 1'b0);
        // Size code 3 acts as 4 bytes, burst (R5)
        run_auto(32'h500, 32'h600, 2, 2'd3, 2'd1, 2'd1, 1'b1, 1'b1);

        // R7 zero count completes at once
        wr(2'd3, 32'h2);
        wr(2'd2, 32'd0);
        rises = 0;
        wr(2'd3, ctrl(1'b1, 1'b1, 2'd2, 2'd1, 2'd1, 1'b1, 1'b0));
        repeat (5) @(negedge clk);
        rd_chk(2'd3, ctrl(1'b0, 1'b1, 2'd2, 2'd1, 2'd1, 1'b1, 1'b0) | 32'h2, "R7 zero count done");
        chk("R7 no bus request", rises, 32'd0);
        chk("R7 irq raised", {31'd0, irq}, 32'd1);

        // Request mode, burst bit set but ignored (R10, R3)
        wr(2'd3, 32'h2);
        push_exp(32'h700, 32'h740, 3, 2'd2, 2'd1, 2'd1, fs, fd);
        wr(2'd0, 32'h700); wr(2'd1, 32'h740); wr(2'd2, 32'd3);
        rises = 0;
        wr(2'd3, ctrl(1'b1, 1'b1, 2'd2, 2'd1, 2'd1, 1'b0, 1'b1));
        repeat (20) @(negedge clk);
        rd_chk(2'd2, 32'd3, "R10 no unit without request");
        chk("R10 no bus request without dreq", rises, 32'd0);
        wr(2'd0, 32'h0000_DEAD);
        rd_chk(2'd0, 32'h700, "R3 source write ignored while enabled");
        wr(2'd2, 32'd9);
        rd_chk(2'd2, 32'd3, "R3 count write ignored while enabled");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); dreq = 1'b1;
            @(negedge clk); dreq = 1'b0;
        end
        wait_done();
        chk("R10 all requested units moved", expq.size(), 32'd0);
        chk("R10 bus released after each unit", rises, 32'd3);
        rd_chk(2'd0, fs, "R10 final source address");
        rd_chk(2'd2, 32'd0, "R10 count zero");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule